// File: doc/BRIEF.md
# Serial Receive Character Buffer

This block sits between the deserializer of a serial receiver and a 16-bit CPU read port. Each time the deserializer finishes a character, it presents the eight data bits with a framing-error bit and a parity-error bit on a valid/ready input. The block stores the character and its error bits, raises a receive-ready flag and, if enabled, an interrupt request. When the CPU reads the buffer, the ready status clears.

The block has two modes. In single-holder mode it holds one character and reports the error bits as zero. In queue mode it holds up to `DEPTH` characters. Each entry keeps its own error bits, and the read word always shows the error bits of the oldest stored character. The deserializer cannot stall, so back-pressure is advisory. `char_ready` is low while no room is left. A character presented with `char_valid` while `char_ready` is low is discarded and sets a sticky overrun flag. `char_ready` does not depend on `rd_strobe`, so a read in the same cycle does not make room for a character that arrives while the buffer is full.

The read word is combinational from the oldest entry. The value the CPU samples while `rd_strobe` is high is therefore the value that the strobe removes. `fifo_mode` must only change while the buffer is empty.

Top module: `rx_char_buffer`

## Requirements
- R1: A character accepted (`char_valid` and `char_ready` high at a clock edge) sets `rx_ready` from that edge on. `rx_ready` stays high as long as at least one character is stored.
- R2: `rx_irq` is a level equal to `rx_ready` AND `rx_int_en`. It falls at the same edge at which a read removes the last stored character.
- R3: A clock edge with `rd_strobe` high while `rx_ready` is high removes the oldest character. When the last character is removed, `rx_ready` goes low. A strobe while the buffer is empty has no effect.
- R4: Reset (`rst_n` low) empties the buffer, clears `overrun`, and drives `rd_word`, `rx_ready` and `rx_irq` to zero.
- R5: `rd_word` carries the character in bits 7..0, the parity-error flag in bit 14 and the framing-error flag in bit 15. Bits 13..8 read zero, and the whole word reads zero while the buffer is empty.
- R6: With `fifo_mode`=1, up to `DEPTH` (4) characters are held and read back in arrival order. Bits 15 and 14 always belong to the oldest stored character.
- R7: With `fifo_mode`=0, only one character is held, `char_ready` is low while it is unread, and bits 15 and 14 of `rd_word` read zero.
- R8: A character presented while `char_ready` is low is discarded without changing the stored contents, and it sets `overrun`. Only reset clears `overrun`.
- R9: An accepted character and a read at the same edge leave the stored count unchanged. The character removed is the old oldest one, and the new character goes to the back.
- R10: The `rd_word` value seen while `rd_strobe` is high, before the edge, is the character that the strobe removes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = queue mode, 0 = single holder |
| rx_int_en | input | 1 | Receive interrupt enable |
| char_valid | input | 1 | Deserializer has a finished character |
| char_data | input | 8 | Received character |
| char_fe | input | 1 | Framing error of the character |
| char_pe | input | 1 | Parity error of the character |
| char_ready | output | 1 | Room for one more character |
| rd_strobe | input | 1 | CPU read of the buffer word |
| rd_word | output | 16 | Read word (oldest character and its flags) |
| rx_ready | output | 1 | At least one character stored |
| rx_irq | output | 1 | Receive interrupt request (level) |
| overrun | output | 1 | Sticky flag for a dropped character |

## Verification
Every cycle, the assertions check the following:
- An accepted character makes `rx_ready` high.
- A drop always leaves `overrun` set, and `overrun` never falls outside reset.
- An empty buffer shows a zero word and no interrupt.
- Single-holder mode masks the error bits and holds at most one character.

Only the bench's scenarios show arrival order across a full queue, error bits travelling with each entry, the old head leaving on a simultaneous push and pop, and the word seen during a strobe being the one consumed.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int CHAR_W = 8;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxbuf_queue.sv
module rxbuf_queue
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  logic      pop,
  input  logic      cap_one,
  input  rx_entry_t wr_entry,
  output rx_entry_t head,
  output logic      not_empty,
  output logic      has_room
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rx_entry_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= wr_entry;
        wr_ptr        <= next_ptr(wr_ptr);
      end
      if (pop) rd_ptr <= next_ptr(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head      = slots[rd_ptr];
  assign not_empty = (count != '0);
  assign has_room  = cap_one ? (count == '0) : (count != FULL_CNT);
endmodule

// File: rtl/rxbuf_overrun.sv
module rxbuf_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (drop) flag <= 1'b1;
  end
endmodule

// File: rtl/rxbuf_format.sv
module rxbuf_format
  import rxbuf_pkg::*;
(
  input  rx_entry_t           head,
  input  logic                not_empty,
  input  logic                fifo_mode,
  output logic [WORD_W-1:0]   word
);
  localparam int GAP_W = WORD_W - CHAR_W - 2;

  always_comb begin
    if (not_empty)
      word = {head.fe & fifo_mode, head.pe & fifo_mode, {GAP_W{1'b0}}, head.data};
    else
      word = '0;
  end
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              rx_int_en,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_fe,
  input  logic              char_pe,
  output logic              char_ready,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_word,
  output logic              rx_ready,
  output logic              rx_irq,
  output logic              overrun
);
  rx_entry_t in_entry, head;
  logic      not_empty, has_room, push, pop, drop;

  assign in_entry = '{fe: char_fe, pe: char_pe, data: char_data};
  assign push     = char_valid && has_room;
  assign drop     = char_valid && !has_room;
  assign pop      = rd_strobe && not_empty;

  rxbuf_queue #(.DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .cap_one(!fifo_mode),
    .wr_entry(in_entry), .head(head), .not_empty(not_empty), .has_room(has_room)
  );

  rxbuf_overrun ovr_i (.clk(clk), .rst_n(rst_n), .drop(drop), .flag(overrun));

  rxbuf_format fmt_i (
    .head(head), .not_empty(not_empty), .fifo_mode(fifo_mode), .word(rd_word)
  );

  assign char_ready = has_room;
  assign rx_ready   = not_empty;
  assign rx_irq     = not_empty && rx_int_en;
endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fifo_mode,
  input logic        char_valid,
  input logic        char_ready,
  input logic        rd_strobe,
  input logic [15:0] rd_word,
  input logic        rx_ready,
  input logic        rx_irq,
  input logic        overrun
);
  // R1
  accept_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_ready && !rd_strobe) |=> rx_ready);

  // R8
  drop_sets_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready) |=> overrun);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R5
  empty_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (rd_word == 16'h0000));

  // R2
  no_irq_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !rx_irq);

  // R7
  single_mask_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> (rd_word[15:14] == 2'b00));

  // R7
  single_capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && rx_ready) |-> !char_ready);
endmodule

bind rx_char_buffer rx_char_buffer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .char_valid(char_valid),
  .char_ready(char_ready), .rd_strobe(rd_strobe), .rd_word(rd_word),
  .rx_ready(rx_ready), .rx_irq(rx_irq), .overrun(overrun)
);

// File: tb/rx_char_buffer_tb_top.sv
module rx_char_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b1;
  logic        rx_int_en = 1'b1;
  logic        char_valid = 1'b0;
  logic [7:0]  char_data = 8'h00;
  logic        char_fe = 1'b0;
  logic        char_pe = 1'b0;
  logic        char_ready;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_word;
  logic        rx_ready, rx_irq, overrun;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_char_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_int_en(rx_int_en),
    .char_valid(char_valid), .char_data(char_data), .char_fe(char_fe),
    .char_pe(char_pe), .char_ready(char_ready), .rd_strobe(rd_strobe),
    .rd_word(rd_word), .rx_ready(rx_ready), .rx_irq(rx_irq), .overrun(overrun)
  );

  // {push, rd, fe, pe, data[7:0], exp_ready, exp_word[15:0]}; queue mode, irq enabled
  localparam int NV = 14;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,8'hA1,1'b1,16'h40A1},  // R1 R5 first char, pe flag
    {1'b1,1'b0,1'b1,1'b0,8'hB2,1'b1,16'h40A1},  // R6 head flags stay with A1
    {1'b1,1'b0,1'b0,1'b0,8'hC3,1'b1,16'h40A1},  // R6
    {1'b1,1'b0,1'b1,1'b1,8'hD4,1'b1,16'h40A1},  // R6 now full
    {1'b1,1'b0,1'b0,1'b0,8'hE5,1'b1,16'h40A1},  // R8 dropped
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b1,16'h80B2},  // R3 R6 pop A1
    {1'b1,1'b1,1'b0,1'b0,8'hF6,1'b1,16'h00C3},  // R9 push+pop
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b1,16'hC0D4},  // R6
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b1,16'h00F6},  // R9 F6 went to back
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0000},  // R3 last read
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0000},  // R3 read on empty
    {1'b1,1'b0,1'b0,1'b1,8'h5A,1'b1,16'h405A},  // R1
    {1'b1,1'b1,1'b1,1'b0,8'h3C,1'b1,16'h803C},  // R9 push+pop at count 1
    {1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,16'h0000}   // R2 R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_char(input logic [7:0] d, input logic fe, input logic pe);
    char_valid = 1'b1; char_data = d; char_fe = fe; char_pe = pe;
    step();
    char_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 word", rd_word, 16'h0000);
    chk("R4 ready", {15'd0, rx_ready}, 16'd0);
    chk("R4 irq", {15'd0, rx_irq}, 16'd0);
    chk("R4 overrun", {15'd0, overrun}, 16'd0);
    chk("R8 room", {15'd0, char_ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      char_valid = v[28]; rd_strobe = v[27];
      char_fe = v[26]; char_pe = v[25]; char_data = v[24:17];
      step();
      char_valid = 1'b0; rd_strobe = 1'b0;
      chk("R6 table word", rd_word, v[15:0]);
      chk("R1 table ready", {15'd0, rx_ready}, {15'd0, v[16]});
      chk("R2 table irq", {15'd0, rx_irq}, {15'd0, v[16]});
    end
    chk("R8 overrun sticky", {15'd0, overrun}, 16'd1);

    do_reset();
    chk("R4 overrun cleared", {15'd0, overrun}, 16'd0);

    // R7 single-holder mode
    fifo_mode = 1'b0;
    push_char(8'h77, 1'b1, 1'b1);
    chk("R7 masked flags", rd_word, 16'h0077);
    chk("R7 no room", {15'd0, char_ready}, 16'd0);
    push_char(8'h88, 1'b0, 1'b0);
    chk("R8 contents kept", rd_word, 16'h0077);
    chk("R8 overrun set", {15'd0, overrun}, 16'd1);
    rd_strobe = 1'b1;
    #1;
    chk("R10 word during strobe", rd_word, 16'h0077);
    step();
    rd_strobe = 1'b0;
    chk("R3 ready cleared", {15'd0, rx_ready}, 16'd0);
    chk("R5 empty word", rd_word, 16'h0000);

    // R2 enable gating
    rx_int_en = 1'b0;
    push_char(8'h99, 1'b0, 1'b0);
    chk("R2 irq gated", {15'd0, rx_irq}, 16'd0);
    rx_int_en = 1'b1;
    #1;
    chk("R2 irq enabled", {15'd0, rx_irq}, 16'd1);
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
    chk("R2 irq falls on read", {15'd0, rx_irq}, 16'd0);

    // R4 reset with data stored
    push_char(8'h11, 1'b0, 1'b0);
    do_reset();
    chk("R4 data cleared", rd_word, 16'h0000);
    chk("R4 ready cleared", {15'd0, rx_ready}, 16'd0);

    finish_run();
  end
endmodule